// File: doc/BRIEF.md
# Multi-Latency Predicated Writeback Pipeline

This block models the result-timing side of one half of a wide-issue datapath. On each cycle it can accept one operation. The operation's result value has already been computed. Along with the value, the operation carries a latency class, a destination register, a predicate register and a predicate polarity. The block holds each result for the number of delay slots set by its class. When that time is up, it writes the result into a 32-entry register file, but only if the predicate allows it at that moment.

The predicate is read in the cycle just before the write takes place, not when the operation is issued. A write that lands on the predicate register while the operation is still in flight is therefore observed. Operations overlap freely, so once the delay lines are full a result can retire on every cycle. A branch-class operation writes no register. Instead, when its delay expires and its predicate passes, it pulses a redirect output. A combinational read port exposes the register file.

Top module: `dwb_core`

## Requirements
- R1: Class code 0 (single-cycle) has zero delay slots. An operation issued in cycle c is visible on the read port from cycle c+1.
- R2: Class code 1 (integer or new floating multiply) has one delay slot. Its result is visible from cycle c+2.
- R3: Class code 2 (legacy floating multiply) has two delay slots. Its result is visible from cycle c+3.
- R4: Class code 3 (load) has four delay slots. Its result is visible from cycle c+5.
- R5: Class code 4 (branch) writes no register. If its predicate passes, `redirect` is high for exactly one cycle, in cycle c+6.
- R6: Predicate index 31 (all ones) always executes. Otherwise, with `iss_pneg`=0 the operation executes when the predicate register is nonzero, and with `iss_pneg`=1 it executes when that register is zero. A failing operation's result is discarded.
- R7: The predicate is evaluated from register contents in the cycle immediately before the write edge. A write that landed on the previous edge is seen, and a write on the same edge is not.
- R8: One operation can be accepted every cycle, and operations of different classes overlap in flight. With back-to-back issue, a result retires every cycle.
- R9: A synchronous active-high `rst` clears the register file, `redirect` and `wb_clash`, and drops every operation still in flight.
- R10: When several passing operations write the same register on the same edge, the one issued latest (the smallest delay) wins. `wb_clash` is then high for the cycle after that edge. Operations whose predicates fail do not count towards a clash.
- R11: Class codes 5, 6 and 7 are ignored: they write nothing and cause no redirect.
- R12: The read port is combinational from `rd_idx`, and a register write becomes visible on the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | An operation is offered this cycle |
| iss_cls | input | 3 | Latency class code |
| iss_dst | input | 5 | Destination register index |
| iss_val | input | 32 | Precomputed result value |
| iss_pidx | input | 5 | Predicate register index (31 means always) |
| iss_pneg | input | 1 | Predicate polarity: 0 tests nonzero, 1 tests zero |
| rd_idx | input | 5 | Read port register index |
| rd_data | output | 32 | Read port data |
| redirect | output | 1 | One-cycle branch-taken strobe |
| wb_clash | output | 1 | Same-register retirement collision, one cycle |

## Verification
The bench builds the block with its default parameters: 32 registers of 32 bits and delay slots of 0, 1, 2, 4 and 5. Random destinations are confined to eight registers and predicates to four registers plus the always index. This makes same-edge collisions, predicate writes inside the sampling window and zero-valued predicates frequent, not rare. A cycle-accurate reference model built from the class delays compares the whole register file and both strobes every cycle. This covers single-class runs, mixed overlap, illegal class codes and a reset while loads are in flight.

// File: rtl/dwb_pkg.sv
`timescale 1ns/1ps
package dwb_pkg;
   localparam int CW   = 3;
   localparam int NCLS = 5;

   typedef enum logic [CW-1:0] {
      CLS_ALU    = 3'd0,
      CLS_IMUL   = 3'd1,
      CLS_FMUL   = 3'd2,
      CLS_LOAD   = 3'd3,
      CLS_BRANCH = 3'd4
   } cls_e;

   localparam int BR_LANE = int'(CLS_BRANCH);
endpackage

// File: rtl/dwb_dline.sv
`timescale 1ns/1ps
module dwb_dline #(
   parameter int DEPTH = 1,
   parameter int DW    = 32,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_vld,
   input  logic [AW-1:0] in_dst,
   input  logic [DW-1:0] in_val,
   input  logic [AW-1:0] in_pidx,
   input  logic          in_pneg,
   output logic          out_vld,
   output logic [AW-1:0] out_dst,
   output logic [DW-1:0] out_val,
   output logic [AW-1:0] out_pidx,
   output logic          out_pneg
);
   if (DEPTH < 0) begin : g_bad_depth
      $error("dwb_dline: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_thru
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst;
      assign out_vld  = in_vld;
      assign out_dst  = in_dst;
      assign out_val  = in_val;
      assign out_pidx = in_pidx;
      assign out_pneg = in_pneg;
   end else begin : g_shift
      logic [DEPTH-1:0] sv;
      logic [AW-1:0]    sd [DEPTH];
      logic [DW-1:0]    sx [DEPTH];
      logic [AW-1:0]    sp [DEPTH];
      logic [DEPTH-1:0] sn;

      always_ff @(posedge clk) begin
         if (rst) sv <= '0;
         else begin
            sv[0] <= in_vld;
            for (int i = 1; i < DEPTH; i++) sv[i] <= sv[i-1];
         end
      end

      always_ff @(posedge clk) begin
         sd[0] <= in_dst;
         sx[0] <= in_val;
         sp[0] <= in_pidx;
         sn[0] <= in_pneg;
         for (int i = 1; i < DEPTH; i++) begin
            sd[i] <= sd[i-1];
            sx[i] <= sx[i-1];
            sp[i] <= sp[i-1];
            sn[i] <= sn[i-1];
         end
      end

      assign out_vld  = sv[DEPTH-1];
      assign out_dst  = sd[DEPTH-1];
      assign out_val  = sx[DEPTH-1];
      assign out_pidx = sp[DEPTH-1];
      assign out_pneg = sn[DEPTH-1];
   end
endmodule

// File: rtl/dwb_pred.sv
`timescale 1ns/1ps
module dwb_pred #(
   parameter int DW = 32,
   parameter int AW = 5
) (
   input  logic          vld,
   input  logic [AW-1:0] pidx,
   input  logic          pneg,
   input  logic [DW-1:0] pval,
   output logic          pass
);
   logic nz;
   assign nz   = |pval;
   assign pass = vld & ((&pidx) | (pneg ? ~nz : nz));
endmodule

// File: rtl/dwb_rf.sv
`timescale 1ns/1ps
module dwb_rf #(
   parameter int NREG = 32,
   parameter int DW   = 32,
   parameter int NRD  = 2,
   localparam int AW  = $clog2(NREG)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     we,
   input  logic [AW-1:0]            wa,
   input  logic [DW-1:0]            wd,
   input  logic [NRD-1:0][AW-1:0]   ra,
   output logic [NRD-1:0][DW-1:0]   rd
);
   if (NRD < 1) begin : g_bad_nrd
      $error("dwb_rf: at least one read port required");
   end

   logic [DW-1:0] mem [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wa] <= wd;
      end
   end

   for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rd[k] = mem[ra[k]];
   end

   // R9: every read port sees zero right after reset
   a_r9_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (rd == '0));

   // R12: a written value is held in the array on the next cycle
   a_r12_write_visible: assert property (@(posedge clk) disable iff (rst)
      we |=> (mem[$past(wa)] == $past(wd)));
endmodule

// File: rtl/dwb_core.sv
`timescale 1ns/1ps
module dwb_core
   import dwb_pkg::*;
#(
   parameter int NREG     = 32,
   parameter int DW       = 32,
   parameter int DLY_MUL  = 1,
   parameter int DLY_FMUL = 2,
   parameter int DLY_LOAD = 4,
   parameter int DLY_BR   = 5,
   localparam int AW      = $clog2(NREG),
   localparam int NRD     = NCLS + 1,
   localparam int CNTW    = $clog2(NCLS + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          iss_vld,
   input  logic [CW-1:0] iss_cls,
   input  logic [AW-1:0] iss_dst,
   input  logic [DW-1:0] iss_val,
   input  logic [AW-1:0] iss_pidx,
   input  logic          iss_pneg,
   input  logic [AW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   output logic          redirect,
   output logic          wb_clash
);
   if ((1 << AW) != NREG) begin : g_bad_nreg
      $error("dwb_core: NREG must be a power of two");
   end
   if (!(0 < DLY_MUL && DLY_MUL < DLY_FMUL && DLY_FMUL < DLY_LOAD && DLY_LOAD < DLY_BR))
   begin : g_bad_dly
      $error("dwb_core: class delays must rise strictly above zero");
   end

   function automatic int cls_dly(int k);
      case (k)
         0:       return 0;
         1:       return DLY_MUL;
         2:       return DLY_FMUL;
         3:       return DLY_LOAD;
         default: return DLY_BR;
      endcase
   endfunction

   logic [NCLS-1:0] hv, hn, pass, wok;
   logic [AW-1:0]   hd [NCLS];
   logic [DW-1:0]   hx [NCLS];
   logic [AW-1:0]   hp [NCLS];
   logic [NRD-1:0][AW-1:0] ra;
   logic [NRD-1:0][DW-1:0] rdat;

   for (genvar k = 0; k < NCLS; k++) begin : g_lane
      logic lane_in;
      assign lane_in = iss_vld && (iss_cls == CW'(k));

      dwb_dline #(.DEPTH(cls_dly(k)), .DW(DW), .AW(AW)) i_line (
         .clk      (clk),
         .rst      (rst),
         .in_vld   (lane_in),
         .in_dst   (iss_dst),
         .in_val   (iss_val),
         .in_pidx  (iss_pidx),
         .in_pneg  (iss_pneg),
         .out_vld  (hv[k]),
         .out_dst  (hd[k]),
         .out_val  (hx[k]),
         .out_pidx (hp[k]),
         .out_pneg (hn[k])
      );

      assign ra[k] = hp[k];

      dwb_pred #(.DW(DW), .AW(AW)) i_pred (
         .vld  (hv[k]),
         .pidx (hp[k]),
         .pneg (hn[k]),
         .pval (rdat[k]),
         .pass (pass[k])
      );

      if (k == BR_LANE) begin : g_br
         assign wok[k] = 1'b0;
      end else begin : g_wr
         assign wok[k] = pass[k];
      end
   end

   assign ra[NCLS] = rd_idx;
   assign rd_data  = rdat[NCLS];

   logic            wr_en;
   logic [AW-1:0]   wr_idx;
   logic [DW-1:0]   wr_data;
   logic [NCLS-1:0] win_oh;
   logic [CNTW-1:0] nsame;
   logic            clash_d;

   always_comb begin
      wr_en   = 1'b0;
      wr_idx  = '0;
      wr_data = '0;
      win_oh  = '0;
      for (int k = 0; k < NCLS; k++) begin
         if (wok[k] && !wr_en) begin
            wr_en     = 1'b1;
            wr_idx    = hd[k];
            wr_data   = hx[k];
            win_oh[k] = 1'b1;
         end
      end
   end

   always_comb begin
      nsame = '0;
      for (int k = 0; k < NCLS; k++) begin
         if (wok[k] && (hd[k] == wr_idx)) nsame = nsame + 1'b1;
      end
      clash_d = (nsame > CNTW'(1));
   end

   dwb_rf #(.NREG(NREG), .DW(DW), .NRD(NRD)) i_rf (
      .clk (clk),
      .rst (rst),
      .we  (wr_en),
      .wa  (wr_idx),
      .wd  (wr_data),
      .ra  (ra),
      .rd  (rdat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         redirect <= 1'b0;
         wb_clash <= 1'b0;
      end else begin
         redirect <= pass[BR_LANE];
         wb_clash <= clash_d;
      end
   end

   // R1: an always-true single-cycle op writes on its issue edge
   a_r1_single_writes: assert property (@(posedge clk) disable iff (rst)
      (iss_vld && iss_cls == CLS_ALU && (&iss_pidx)) |-> wr_en);

   // R10: at most one lane wins the write port
   a_r10_one_winner: assert property (@(posedge clk) disable iff (rst)
      $onehot0(win_oh));

   // R5: a redirect traces back to a branch reaching the end of its line
   a_r5_redirect_src: assert property (@(posedge clk) disable iff (rst)
      redirect |-> $past(hv[BR_LANE]));

   // R11: an illegal class code with no older op retiring writes nothing
   a_r11_bad_class_idle: assert property (@(posedge clk) disable iff (rst)
      (iss_vld && iss_cls > CLS_BRANCH && !(|hv[NCLS-1:1])) |-> !wr_en);
endmodule

// File: tb/test_dwb_core.sv
`timescale 1ns/1ps
module test_dwb_core;
   logic        clk = 1'b0;
   logic        rst;
   logic        iss_vld;
   logic [2:0]  iss_cls;
   logic [4:0]  iss_dst;
   logic [31:0] iss_val;
   logic [4:0]  iss_pidx;
   logic        iss_pneg;
   logic [4:0]  rd_idx;
   logic [31:0] rd_data;
   logic        redirect;
   logic        wb_clash;

   always #2.5 clk = ~clk;

   dwb_core i_dwb_core (
      .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_cls(iss_cls),
      .iss_dst(iss_dst), .iss_val(iss_val), .iss_pidx(iss_pidx),
      .iss_pneg(iss_pneg), .rd_idx(rd_idx), .rd_data(rd_data),
      .redirect(redirect), .wb_clash(wb_clash)
   );

   int nvec = 0;
   int nbad = 0;
   int ecnt = 0;
   bit done = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   logic [31:0] mrf [32];
   bit          ev_v [8][5];
   logic [4:0]  ev_d [8][5];
   logic [31:0] ev_x [8][5];
   logic [4:0]  ev_p [8][5];
   bit          ev_n [8][5];
   bit          exp_redir = 1'b0;
   bit          exp_clash = 1'b0;

   function automatic int dly(int c);
      case (c)
         0: return 0;
         1: return 1;
         2: return 2;
         3: return 4;
         default: return 5;
      endcase
   endfunction

   function automatic bit pred_ok(logic [4:0] p, bit n);
      if (p == 5'd31) return 1'b1;
      return n ? (mrf[p] == 0) : (mrf[p] != 0);
   endfunction

   task automatic model_edge();
      int s;
      bit got;
      bit ok [5];
      logic [4:0] wd;
      logic [31:0] wx;
      int same;
      if (rst) begin
         for (int r = 0; r < 32; r++) mrf[r] = '0;
         for (int i = 0; i < 8; i++)
            for (int c = 0; c < 5; c++) ev_v[i][c] = 1'b0;
         exp_redir = 1'b0;
         exp_clash = 1'b0;
      end else begin
         if (iss_vld && iss_cls <= 3'd4) begin
            s = (ecnt + dly(int'(iss_cls))) % 8;
            ev_v[s][iss_cls] = 1'b1;
            ev_d[s][iss_cls] = iss_dst;
            ev_x[s][iss_cls] = iss_val;
            ev_p[s][iss_cls] = iss_pidx;
            ev_n[s][iss_cls] = iss_pneg;
         end
         s = ecnt % 8;
         for (int c = 0; c < 5; c++) ok[c] = ev_v[s][c] && pred_ok(ev_p[s][c], ev_n[s][c]);
         got = 1'b0; wd = '0; wx = '0;
         for (int c = 0; c < 4; c++)
            if (ok[c] && !got) begin got = 1'b1; wd = ev_d[s][c]; wx = ev_x[s][c]; end
         same = 0;
         for (int c = 0; c < 4; c++) if (ok[c] && ev_d[s][c] == wd) same++;
         exp_clash = got && (same > 1);
         exp_redir = ok[4];
         if (got) mrf[wd] = wx;
         for (int c = 0; c < 5; c++) ev_v[s][c] = 1'b0;
      end
      ecnt++;
   endtask

   task automatic check_all(string tag);
      nvec++;
      if (redirect !== exp_redir) begin
         nbad++;
         $display("FAIL %s redirect got %b exp %b (cycle %0d)", tag, redirect, exp_redir, ecnt);
      end
      nvec++;
      if (wb_clash !== exp_clash) begin
         nbad++;
         $display("FAIL %s wb_clash got %b exp %b (cycle %0d)", tag, wb_clash, exp_clash, ecnt);
      end
      for (int r = 0; r < 32; r++) begin
         rd_idx = 5'(r);
         #0.05;
         nvec++;
         if (rd_data !== mrf[r]) begin
            nbad++;
            $display("FAIL %s reg %0d got %h exp %h (cycle %0d)", tag, r, rd_data, mrf[r], ecnt);
         end
      end
   endtask

   task automatic tick(string tag);
      model_edge();
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic issue(string tag, int c, int d, logic [31:0] x, int p, bit n);
      iss_vld = 1'b1; iss_cls = 3'(c); iss_dst = 5'(d);
      iss_val = x; iss_pidx = 5'(p); iss_pneg = n;
      tick(tag);
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++) begin
         iss_vld = 1'b0;
         tick(tag);
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
   endtask

   // mode 0..4: one class only; 5: mixed legal; 6: mixed incl. illegal codes
   task automatic run_phase(string tag, int mode, int n);
      int c;
      int p;
      logic [31:0] x;
      for (int i = 0; i < n; i++) begin
         step_lfsr();
         if (mode <= 4) c = mode;
         else if (mode == 5) c = int'(lfsr[2:0]) % 5;
         else c = int'(lfsr[2:0]);
         p = (lfsr[5:3] > 3'd3) ? 31 : int'(lfsr[4:3]);
         step_lfsr();
         x = (lfsr[1:0] == 2'b00) ? 32'd0 : lfsr;
         step_lfsr();
         if (lfsr[3:0] == 4'd0) begin
            iss_vld = 1'b0;
            tick(tag);
         end else begin
            issue(tag, c, int'(lfsr[10:8]), x, p, lfsr[12]);
         end
      end
   endtask

   initial begin
      rst = 1'b1; iss_vld = 1'b0; iss_cls = '0; iss_dst = '0;
      iss_val = '0; iss_pidx = '0; iss_pneg = 1'b0; rd_idx = '0;
      tick("R9");
      tick("R9");
      rst = 1'b0;
      idle("R9", 2);

      // R1 / R12: single-cycle writes then immediate dependent reads
      issue("R1", 0, 9, 32'hCAFE_0001, 31, 0);
      issue("R12", 0, 9, 32'hCAFE_0002, 31, 0);
      run_phase("R1", 0, 150);
      run_phase("R2", 1, 150);
      run_phase("R3", 2, 150);
      run_phase("R4", 3, 150);
      run_phase("R5", 4, 150);

      // R6: polarity and always index on a known predicate
      issue("R6", 0, 2, 32'd0, 31, 0);
      issue("R6", 0, 12, 32'h1111, 2, 0);
      issue("R6", 0, 13, 32'h2222, 2, 1);
      issue("R6", 0, 2, 32'd5, 31, 0);
      issue("R6", 0, 14, 32'h3333, 2, 0);
      issue("R6", 0, 15, 32'h4444, 2, 1);
      idle("R6", 2);

      // R7: predicate written inside the window is observed, same edge is not
      issue("R7", 0, 1, 32'd0, 31, 0);
      issue("R7", 2, 20, 32'h0000_00AB, 1, 0);
      issue("R7", 0, 1, 32'd7, 31, 0);
      idle("R7", 3);
      issue("R7", 2, 21, 32'h0000_00CD, 1, 0);
      idle("R7", 1);
      issue("R7", 0, 1, 32'd0, 31, 0);
      idle("R7", 3);

      // R10: load and single op landing on the same edge
      issue("R10", 3, 4, 32'h11, 31, 0);
      idle("R10", 3);
      issue("R10", 0, 4, 32'h22, 31, 0);
      idle("R10", 2);
      issue("R10", 0, 3, 32'd0, 31, 0);
      issue("R10", 3, 4, 32'h33, 31, 0);
      idle("R10", 3);
      issue("R10", 0, 4, 32'h44, 3, 0);
      idle("R10", 2);

      run_phase("R6", 5, 300);
      run_phase("R8", 5, 400);
      run_phase("R11", 6, 300);

      // R9: reset while loads and a branch are in flight
      issue("R9", 3, 2, 32'h5555, 31, 0);
      issue("R9", 3, 3, 32'h6666, 31, 0);
      issue("R9", 4, 0, 32'h0, 31, 0);
      iss_vld = 1'b0;
      rst = 1'b1;
      tick("R9");
      rst = 1'b0;
      idle("R9", 8);

      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nbad++;
         $display("FAIL watchdog expired got timeout exp completion");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule